// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for each bus access of a small processor, whether the access may proceed. Eight regions are programmed through parallel configuration inputs that a separate register block drives. Each region has a base address, a power-of-two size, eight sub-region disable bits, a three-bit read/write permission code and an execute-never bit. The checker compares an access against all enabled regions in parallel. It lets the highest-numbered matching region decide and applies that region's permission to the access kind and privilege level. It then reports allow or deny one cycle later.

A denied access raises a one-cycle memory-management fault pulse, and the address of that access is captured in a fault address register. Three global controls shape the decision. One turns checking on or off. One gives privileged code a default map where no region matches. One keeps checking active while the processor is in a hard-fault or non-maskable exception context.

Top module: `mpu_guard`

## Requirements
- R1: With `cfg_unit_on` low, every access is allowed and no fault pulse is raised.
- R2: A region with size field N (4..31) spans 2^(N+1) bytes and matches when address bits [31:N+1] equal the same bits of its base. A size field below 4 never matches, and a region with its enable bit low never matches.
- R3: For N >= 7 (256 bytes or more), the region is split into eight equal sub-regions. Sub-region k is selected by address bits [N:N-2] equal to k. Setting disable bit k removes that sub-region from the region's match.
- R4: For N < 7, the sub-region disable bits are ignored and the whole region matches.
- R5: The permission codes are as follows. 0: no access in either mode. 1: privileged read/write, user none. 2: privileged read/write, user read. 3: read/write in both modes. 5: privileged read, user none. 6: read in both modes. Codes 4 and 7 deny all access. A write needs write permission; a read or fetch needs read permission. Access kinds are encoded as 0 read, 1 write, 2 fetch.
- R6: A fetch (kind 2) that resolves to a region whose execute-never bit is set is denied, even where reads are allowed.
- R7: An access that matches no region is allowed only if it is privileged and `cfg_priv_map` is high; otherwise it is denied.
- R8: While `acc_exc` is high and `cfg_exc_check` is low, every access is allowed.
- R9: When several regions match, the highest-numbered matching region alone decides the outcome.
- R10: A denied access produces `fault_pulse` high for exactly the response cycle and loads `fault_addr` with the access address. At all other times `fault_addr` holds its value.
- R11: `resp_valid` and `resp_allow` appear on the clock edge after the access is presented. After reset, `resp_valid`, `resp_allow`, `fault_pulse` and `fault_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_exc | input | 1 | Processor is in hard-fault or NMI context |
| cfg_unit_on | input | 1 | Checking enabled |
| cfg_priv_map | input | 1 | Default map for privileged unmatched accesses |
| cfg_exc_check | input | 1 | Keep checking in exception context |
| rgn_on | input | 8 | Per-region enable |
| rgn_base | input | 256 | Region base addresses, region i in bits [32i+31:32i] |
| rgn_size | input | 40 | Region size fields N, region i in bits [5i+4:5i] |
| rgn_subdis | input | 64 | Sub-region disable masks, region i in bits [8i+7:8i] |
| rgn_perm | input | 24 | Permission codes, region i in bits [3i+2:3i] |
| rgn_xn | input | 8 | Per-region execute-never |
| resp_valid | output | 1 | Response for the previous cycle's access |
| resp_allow | output | 1 | Access allowed (low when not valid) |
| fault_pulse | output | 1 | One-cycle memory-management fault |
| fault_addr | output | 32 | Address of the last denied access |

## Verification
The assertions assume that the configuration inputs stay stable while an access is being checked. They also assume that bases are aligned to their region size, because the match ignores the low base bits and an unaligned base would give a region the bench does not expect. The stimulus only rewrites the region set between accesses. It builds every base by masking a random word down to the region's alignment, and it issues only the three defined access kinds. Random addresses are mostly drawn inside chosen regions, so that overlap, sub-region and permission paths are reached as often as misses.

// File: rtl/mpu_pkg.sv
// Package: shared encodings for the memory protection region checker.
// Assumes a 32-bit address space and eight sub-regions per region.
package mpu_pkg;
    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2
    } acc_kind_t;

    // Smallest legal size field (32-byte region) and smallest with sub-regions (256 bytes)
    localparam int SIZE_MIN     = 4;
    localparam int SIZE_SUB_MIN = 7;
    localparam int SUB_COUNT    = 8;
endpackage

// File: rtl/mpu_rgn_match.sv
// Module: address match for one region.
// Decides whether an address lies in the region and in a sub-region that is
// not disabled. Assumes the base is aligned to the region size; low base bits
// are ignored. Size field N gives 2^(N+1) bytes.
module mpu_rgn_match
    import mpu_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 5
) (
    input  logic [AW-1:0]        addr,
    input  logic                 on,
    input  logic [AW-1:0]        base,
    input  logic [SZW-1:0]       size,
    input  logic [SUB_COUNT-1:0] subdis,
    output logic                 hit
);
    localparam int SHW = SZW + 1;

    logic [SHW-1:0] span_shift;
    logic [SHW-1:0] sub_shift;
    logic [AW:0]    upper_mask;
    logic [AW-1:0]  sub_bits;
    logic           in_range;
    logic           sub_off;

    // Purpose: compare upper address bits and look up the sub-region disable bit.
    always_comb begin
        span_shift = {1'b0, size} + SHW'(1);
        sub_shift  = (size >= SZW'(SIZE_SUB_MIN)) ? ({1'b0, size} - SHW'(2)) : '0;
        upper_mask = {(AW+1){1'b1}} << span_shift;
        in_range   = ((({1'b0, addr} ^ {1'b0, base}) & upper_mask) == '0);
        sub_bits   = addr >> sub_shift;
        sub_off    = (size >= SZW'(SIZE_SUB_MIN)) && subdis[sub_bits[2:0]];
        hit        = on && (size >= SZW'(SIZE_MIN)) && in_range && !sub_off;
    end
endmodule

// File: rtl/mpu_perm_eval.sv
// Module: permission evaluation for the region that decides an access.
// Maps the three-bit permission code, access kind, privilege and
// execute-never bit to an allow flag. Unknown codes deny everything.
module mpu_perm_eval
    import mpu_pkg::*;
(
    input  logic [2:0] perm,
    input  logic       xn,
    input  logic [1:0] kind,
    input  logic       priv,
    output logic       ok
);
    logic can_rd;
    logic can_wr;

    // Purpose: decode read and write rights for the current privilege level.
    always_comb begin
        can_rd = 1'b0;
        can_wr = 1'b0;
        unique case (perm)
            3'd1: begin can_rd = priv; can_wr = priv; end
            3'd2: begin can_rd = 1'b1; can_wr = priv; end
            3'd3: begin can_rd = 1'b1; can_wr = 1'b1; end
            3'd5: begin can_rd = priv; end
            3'd6: begin can_rd = 1'b1; end
            default: begin can_rd = 1'b0; can_wr = 1'b0; end
        endcase
    end

    // Purpose: combine rights with the access kind and execute-never.
    always_comb begin
        if (kind == KIND_WRITE) ok = can_wr;
        else if (kind == KIND_FETCH) ok = can_rd && !xn;
        else ok = can_rd;
    end
endmodule

// File: rtl/mpu_guard.sv
// Module: top of the memory protection region checker.
// Matches each access against all regions in parallel, lets the highest
// numbered hit decide, applies global controls and registers the result.
// Assumes region configuration is stable while an access is checked.
module mpu_guard
    import mpu_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic [AW-1:0]            acc_addr,
    input  logic [1:0]               acc_kind,
    input  logic                     acc_priv,
    input  logic                     acc_exc,
    input  logic                     cfg_unit_on,
    input  logic                     cfg_priv_map,
    input  logic                     cfg_exc_check,
    input  logic [NREG-1:0]          rgn_on,
    input  logic [NREG*AW-1:0]       rgn_base,
    input  logic [NREG*$clog2(AW)-1:0] rgn_size,
    input  logic [NREG*8-1:0]        rgn_subdis,
    input  logic [NREG*3-1:0]        rgn_perm,
    input  logic [NREG-1:0]          rgn_xn,
    output logic                     resp_valid,
    output logic                     resp_allow,
    output logic                     fault_pulse,
    output logic [AW-1:0]            fault_addr
);
    localparam int SZW  = $clog2(AW);
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [NREG-1:0] hit;
    logic [IDXW-1:0] sel;
    logic            any_hit;
    logic [2:0]      sel_perm;
    logic            sel_xn;
    logic            perm_ok;
    logic            allow_c;

    // One match unit per region
    for (genvar g = 0; g < NREG; g++) begin : g_rgn
        mpu_rgn_match #(.AW(AW), .SZW(SZW)) u_match (
            .addr   (acc_addr),
            .on     (rgn_on[g]),
            .base   (rgn_base[g*AW +: AW]),
            .size   (rgn_size[g*SZW +: SZW]),
            .subdis (rgn_subdis[g*8 +: 8]),
            .hit    (hit[g])
        );
    end

    // Purpose: pick the highest-numbered region that hits.
    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                sel     = IDXW'(i);
                any_hit = 1'b1;
            end
        end
        sel_perm = rgn_perm[sel*3 +: 3];
        sel_xn   = rgn_xn[sel];
    end

    mpu_perm_eval u_perm (
        .perm (sel_perm),
        .xn   (sel_xn),
        .kind (acc_kind),
        .priv (acc_priv),
        .ok   (perm_ok)
    );

    // Purpose: apply global controls and the default map to the region verdict.
    always_comb begin
        if (!cfg_unit_on) allow_c = 1'b1;
        else if (acc_exc && !cfg_exc_check) allow_c = 1'b1;
        else if (any_hit) allow_c = perm_ok;
        else allow_c = acc_priv && cfg_priv_map;
    end

    // Purpose: register the response, fault pulse and fault address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_allow  <= 1'b0;
            fault_pulse <= 1'b0;
            fault_addr  <= '0;
        end else begin
            resp_valid  <= acc_valid;
            resp_allow  <= acc_valid && allow_c;
            fault_pulse <= acc_valid && !allow_c;
            if (acc_valid && !allow_c) fault_addr <= acc_addr;
        end
    end

    // R1: a disabled unit never denies
    p_off_allows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !cfg_unit_on |=> resp_allow && !fault_pulse);

    // R7: an unmatched user access is denied while checking is active
    p_user_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && cfg_unit_on && !acc_priv && !acc_exc && (hit == '0) |=> fault_pulse);

    // R8: exception context bypasses checking when not kept on
    p_exc_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_exc && !cfg_exc_check |=> resp_allow);

    // R9: the deciding region has no higher-numbered hit above it
    p_top_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((hit >> sel) == NREG'(1)));

    // R10: a fault captures the address of the denied access
    p_fault_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> fault_addr == $past(acc_addr) && resp_valid && !resp_allow);

    // R10: fault address holds when no fault is raised
    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_pulse |-> $stable(fault_addr));

    // R11: one response per access, one cycle later
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid && !fault_pulse);
endmodule

// File: tb/mpu_guard_test.sv
`timescale 1ns/1ps
module mpu_guard_test;
    localparam int NREG = 8;
    localparam int AW   = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic acc_priv = 1'b0, acc_exc = 1'b0;
    logic cfg_unit_on = 1'b0, cfg_priv_map = 1'b0, cfg_exc_check = 1'b0;
    logic resp_valid, resp_allow, fault_pulse;
    logic [31:0] fault_addr;

    logic        r_on   [NREG];
    logic [31:0] r_base [NREG];
    logic [4:0]  r_size [NREG];
    logic [7:0]  r_sub  [NREG];
    logic [2:0]  r_perm [NREG];
    logic        r_xn   [NREG];

    logic [NREG-1:0]    f_on, f_xn;
    logic [NREG*32-1:0] f_base;
    logic [NREG*5-1:0]  f_size;
    logic [NREG*8-1:0]  f_sub;
    logic [NREG*3-1:0]  f_perm;

    for (genvar g = 0; g < NREG; g++) begin : g_pack
        assign f_on[g]           = r_on[g];
        assign f_xn[g]           = r_xn[g];
        assign f_base[g*32 +: 32] = r_base[g];
        assign f_size[g*5 +: 5]   = r_size[g];
        assign f_sub[g*8 +: 8]    = r_sub[g];
        assign f_perm[g*3 +: 3]   = r_perm[g];
    end

    int total = 0;
    int bad = 0;
    logic [31:0] last_fault = '0;

    always #5 clk = ~clk;

    mpu_guard #(.NREG(NREG), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .acc_priv(acc_priv), .acc_exc(acc_exc),
        .cfg_unit_on(cfg_unit_on), .cfg_priv_map(cfg_priv_map), .cfg_exc_check(cfg_exc_check),
        .rgn_on(f_on), .rgn_base(f_base), .rgn_size(f_size), .rgn_subdis(f_sub),
        .rgn_perm(f_perm), .rgn_xn(f_xn),
        .resp_valid(resp_valid), .resp_allow(resp_allow),
        .fault_pulse(fault_pulse), .fault_addr(fault_addr)
    );

    // Reference: does region i contain addr, per size, alignment and sub-region rules
    function automatic bit ref_in(int i, logic [31:0] a);
        longint unsigned span, lo, part;
        if (!r_on[i] || r_size[i] < 4) return 0;
        span = 64'd1 << (r_size[i] + 1);
        lo   = {32'd0, r_base[i]} & ~(span - 1);
        if ({32'd0, a} < lo || {32'd0, a} >= lo + span) return 0;
        if (r_size[i] >= 7) begin
            part = ({32'd0, a} - lo) / (span / 8);
            if (r_sub[i][part[2:0]]) return 0;
        end
        return 1;
    endfunction

    // Reference: full allow decision from the requirements
    function automatic bit ref_allow(logic [31:0] a, logic [1:0] k, bit p, bit e);
        bit rd, wr;
        if (!cfg_unit_on) return 1;
        if (e && !cfg_exc_check) return 1;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (ref_in(i, a)) begin
                case (r_perm[i])
                    3'd1: begin rd = p; wr = p; end
                    3'd2: begin rd = 1; wr = p; end
                    3'd3: begin rd = 1; wr = 1; end
                    3'd5: begin rd = p; wr = 0; end
                    3'd6: begin rd = 1; wr = 0; end
                    default: begin rd = 0; wr = 0; end
                endcase
                if (k == 2'd1) return wr;
                if (k == 2'd2) return rd && !r_xn[i];
                return rd;
            end
        end
        return p && cfg_priv_map;
    endfunction

    task automatic clear_regions();
        for (int i = 0; i < NREG; i++) begin
            r_on[i] = 0; r_base[i] = '0; r_size[i] = '0;
            r_sub[i] = '0; r_perm[i] = '0; r_xn[i] = 0;
        end
    endtask

    task automatic set_rgn(int i, logic [31:0] b, logic [4:0] n, logic [7:0] s, logic [2:0] pm, bit x);
        r_on[i] = 1; r_base[i] = b; r_size[i] = n; r_sub[i] = s; r_perm[i] = pm; r_xn[i] = x;
    endtask

    // Present one access, check the response one clock later
    task automatic access(logic [31:0] a, logic [1:0] k, bit p, bit e, bit exp_allow, string tag);
        logic [31:0] exp_fa;
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_kind = k; acc_priv = p; acc_exc = e;
        @(negedge clk);
        acc_valid = 0;
        exp_fa = exp_allow ? last_fault : a;
        total++;
        if (resp_valid !== 1'b1 || resp_allow !== exp_allow || fault_pulse !== !exp_allow
            || fault_addr !== exp_fa) begin
            bad++;
            $display("FAIL %s addr=%h kind=%0d priv=%0d: valid=%b allow=%b pulse=%b fa=%h expected allow=%b fa=%h",
                tag, a, k, p, resp_valid, resp_allow, fault_pulse, fault_addr, exp_allow, exp_fa);
        end
        last_fault = exp_fa;
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        clear_regions();
        repeat (3) @(negedge clk);
        total++;
        if (resp_valid !== 0 || resp_allow !== 0 || fault_pulse !== 0 || fault_addr !== 0) begin
            bad++;
            $display("FAIL R11 reset: valid=%b allow=%b pulse=%b fa=%h expected all 0",
                resp_valid, resp_allow, fault_pulse, fault_addr);
        end
        rst_n = 1;

        // R1: unit off, no region, user write still allowed
        access(32'h0000_4000, 2'd1, 0, 0, 1, "R1");
        cfg_unit_on = 1;

        // R2: 256-byte region at 0x1000, user rw
        set_rgn(0, 32'h0000_1000, 5'd7, 8'h00, 3'd3, 0);
        access(32'h0000_10FF, 2'd1, 0, 0, 1, "R2 inside");
        access(32'h0000_1100, 2'd0, 0, 0, 0, "R2 outside");
        // R2: size below 4 never matches
        r_size[0] = 5'd3;
        access(32'h0000_1000, 2'd0, 0, 0, 0, "R2 tiny");
        // R2: disabled region does not match
        r_size[0] = 5'd7; r_on[0] = 0;
        access(32'h0000_1000, 2'd0, 0, 0, 0, "R2 off");
        r_on[0] = 1;

        // R3: sub-region 2 disabled (bytes 0x40..0x5F)
        r_sub[0] = 8'h04;
        access(32'h0000_1040, 2'd0, 0, 0, 0, "R3 hole");
        access(32'h0000_1060, 2'd0, 0, 0, 1, "R3 next");

        // R4: 128-byte region ignores sub-region bits
        set_rgn(0, 32'h0000_2000, 5'd6, 8'hFF, 3'd3, 0);
        access(32'h0000_2010, 2'd0, 0, 0, 1, "R4");

        // R5: permission codes
        set_rgn(0, 32'h0000_2000, 5'd6, 8'h00, 3'd6, 0);
        access(32'h0000_2004, 2'd1, 1, 0, 0, "R5 ro write");
        access(32'h0000_2004, 2'd0, 0, 0, 1, "R5 ro read");
        r_perm[0] = 3'd1;
        access(32'h0000_2004, 2'd0, 0, 0, 0, "R5 user none");
        access(32'h0000_2004, 2'd1, 1, 0, 1, "R5 priv rw");
        r_perm[0] = 3'd4;
        access(32'h0000_2004, 2'd0, 1, 0, 0, "R5 reserved");

        // R6: execute-never
        set_rgn(0, 32'h0000_2000, 5'd6, 8'h00, 3'd3, 1);
        access(32'h0000_2008, 2'd2, 1, 0, 0, "R6 fetch");
        access(32'h0000_2008, 2'd0, 1, 0, 1, "R6 read");

        // R7: default map for privileged misses
        cfg_priv_map = 1;
        access(32'h8000_0000, 2'd1, 1, 0, 1, "R7 priv");
        access(32'h8000_0000, 2'd1, 0, 0, 0, "R7 user");
        cfg_priv_map = 0;
        access(32'h8000_0004, 2'd0, 1, 0, 0, "R7 no map");

        // R8: exception bypass
        access(32'h9000_0000, 2'd1, 0, 1, 1, "R8 bypass");
        cfg_exc_check = 1;
        access(32'h9000_0000, 2'd1, 0, 1, 0, "R8 checked");
        cfg_exc_check = 0;

        // R9: overlap, higher number wins
        clear_regions();
        set_rgn(1, 32'h0001_0000, 5'd15, 8'h00, 3'd0, 0);
        set_rgn(5, 32'h0001_0000, 5'd9,  8'h00, 3'd3, 0);
        access(32'h0001_0010, 2'd0, 0, 0, 1, "R9 high open");
        access(32'h0001_0800, 2'd0, 0, 0, 0, "R9 low only");
        r_perm[1] = 3'd3; r_perm[5] = 3'd0;
        access(32'h0001_0010, 2'd0, 0, 0, 0, "R9 high closed");
        // R9 with hole: disabled sub-region falls through to lower region
        r_sub[5] = 8'h01;
        access(32'h0001_0010, 2'd0, 0, 0, 1, "R9 fall through");

        // R10: fault address held across allowed access
        access(32'hDEAD_0000, 2'd0, 0, 0, 0, "R10 fault");
        access(32'h0001_0010, 2'd0, 0, 0, 1, "R10 hold");

        // Random phase
        for (int blk = 0; blk < 40; blk++) begin
            clear_regions();
            for (int i = 0; i < NREG; i++) begin
                logic [4:0] n;
                n = ($urandom % 8 == 0) ? 5'(4 + $urandom % 28) : 5'(4 + $urandom % 10);
                r_on[i]   = ($urandom % 5) != 0;
                r_size[i] = n;
                r_base[i] = 32'($urandom & ~((64'd1 << (n + 1)) - 1));
                r_sub[i]  = 8'($urandom);
                r_perm[i] = 3'($urandom);
                r_xn[i]   = $urandom % 2;
            end
            cfg_unit_on   = ($urandom % 8) != 0;
            cfg_priv_map  = $urandom % 2;
            cfg_exc_check = $urandom % 2;
            for (int t = 0; t < 60; t++) begin
                logic [31:0] a;
                logic [1:0] k;
                bit p, e;
                int j;
                j = $urandom % NREG;
                if ($urandom % 4 != 0)
                    a = 32'(r_base[j] + ($urandom & ((64'd1 << (r_size[j] + 1)) - 1)));
                else
                    a = $urandom;
                k = 2'($urandom % 3);
                p = $urandom % 2;
                e = ($urandom % 6) == 0;
                access(a, k, p, e, ref_allow(a, k, p, e), "R2-random");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule